// File: doc/BRIEF.md
# Bitmap Pattern Magnifier

This block enlarges a one-bit-per-pixel bitmap line by an integer factor in both directions. After a start pulse it captures a magnification factor and a source line length. It then takes the source line as a stream of packed words. Every source pixel becomes a run of identical pixels, as many as the factor. The widened line is packed into output words and sent downstream. Each output word is also written into an internal line store.

Vertical enlargement reuses the line store. Once the first widened line has been accepted downstream, the block sends the stored words again until the line has appeared factor-many times. It does not fetch or recompute the source for these repeats. Horizontal and vertical scale therefore always match, and a glyph or logo keeps its proportions.

Top module: `bitmap_magnifier`

## Requirements
- R1: Source pixel i of a line is the bit at position 31 - (i mod 32) of source word i/32. Each source bit i is repeated F times, where F is the effective factor, and those copies fill positions i*F to i*F+F-1 of the widened line. Source bits beyond the line length in the final source word are ignored.
- R2: The factor input is an integer. Values 1 to 10 are used as given, 0 acts as 1, and values above 10 act as 10.
- R3: The line length input gives the line length in bits. Values 1 to 256 are used as given, 0 acts as 1, and values above 256 act as 256.
- R4: Widened bit k is placed in output word k/32 at position 31 - (k mod 32). Each line has ceil(L*F/32) words. Positions past L*F in the final word are 0. outLast is 1 on the final word of every line and 0 on every other word.
- R5: A run produces exactly F identical lines. Exactly ceil(L/32) source words are accepted per run. srcReady stays low once the last source bit has been taken.
- R6: While outValid is 1 and outReady is 0, the next cycle keeps outValid at 1 and leaves outData and outLast unchanged. No expanded bit is lost or duplicated.
- R7: donePulse is 1 for exactly one cycle: the cycle after the final word of the F-th line is accepted. busy is 0 in that cycle.
- R8: A start pulse that arrives while busy is 1 has no effect on the output stream of the run in progress.
- R9: After reset, busy, outValid, srcReady and donePulse are 0. busy becomes 1 in the cycle after a start pulse that arrives while idle. outValid and srcReady are only 1 while busy is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a run when idle |
| factorIn | input | 4 | Magnification factor, sampled at start |
| lineLenIn | input | 9 | Source line length in bits, sampled at start |
| srcData | input | 32 | Packed source word, MSB first |
| srcValid | input | 1 | Source word offered |
| srcReady | output | 1 | Block accepts a source word |
| outData | output | 32 | Packed widened word, MSB first |
| outValid | output | 1 | Output word offered |
| outReady | input | 1 | Downstream accepts the output word |
| outLast | output | 1 | Marks the final word of a line |
| donePulse | output | 1 | One-cycle run completion |
| busy | output | 1 | A run is in progress |

## Verification
Most internal faults show up in the very next accepted word. A run counter off by one, a bad source bit index, or a wrong accumulator fill position changes the data or the outLast flag of that word. A line-store address fault appears one line later, in the first repeated line. Those words then differ from the widened line that came before them. A fault in the repeat count or in the stop after the last source bit shows up at the end of the run. The number of lines or of source words accepted comes out wrong, or donePulse moves off its expected cycle. The bench sweeps all factors from 0 to 11 over a set of lengths that straddle word boundaries. It compares every word against a model computed arithmetically, with and without back-pressure.

// File: rtl/magnifier_pkg.sv
package magnifier_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXPAND,
    ST_REPLAY
  } magState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCfg;
    logic expandEn;
    logic replayEn;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic expandLineAccepted;
    logic replayLineAccepted;
    logic lastReplay;
    logic singleCopy;
  } dpStatus_t;

endpackage

// File: rtl/magnifier_control.sv
module magnifier_control
  import magnifier_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  dpStatus_t  status,
  output ctlStrobe_t strobes,
  output logic       busy,
  output logic       donePulse
);

  magState_t state;

  always_comb begin
    strobes.loadCfg  = (state == ST_IDLE) && startPulse;
    strobes.expandEn = (state == ST_EXPAND);
    strobes.replayEn = (state == ST_REPLAY);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startPulse) state <= ST_EXPAND;
        end
        ST_EXPAND: begin
          if (status.expandLineAccepted) begin
            if (status.singleCopy) begin
              state     <= ST_IDLE;
              donePulse <= 1'b1;
            end else begin
              state <= ST_REPLAY;
            end
          end
        end
        ST_REPLAY: begin
          if (status.replayLineAccepted && status.lastReplay) begin
            state     <= ST_IDLE;
            donePulse <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/magnifier_datapath.sv
module magnifier_datapath
  import magnifier_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int MAX_LEN    = 256,
  parameter int MAX_FACTOR = 10,
  parameter int FAC_W      = $clog2(MAX_FACTOR + 1),
  parameter int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [FAC_W-1:0]  factorIn,
  input  logic [LEN_W-1:0]  lineLenIn,
  input  logic [WORD_W-1:0] srcData,
  input  logic              srcValid,
  output logic              srcReady,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outLast,
  output dpStatus_t         status
);

  // WORD_W must be a power of two: bit positions are reached by inverting a counter
  localparam int POS_W = $clog2(WORD_W);
  localparam int DEPTH = (MAX_LEN * MAX_FACTOR + WORD_W - 1) / WORD_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [FAC_W-1:0] FAC_ONE = FAC_W'(1);
  localparam logic [FAC_W-1:0] FAC_TWO = FAC_W'(2);
  localparam logic [FAC_W-1:0] FAC_MAX = FAC_W'(MAX_FACTOR);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
  localparam logic [POS_W-1:0] POS_END = POS_W'(WORD_W - 1);

  logic [FAC_W-1:0]  facCfg, facNorm, repCnt, lineCnt;
  logic [LEN_W-1:0]  lenCfg, lenNorm, bitCnt;
  logic [WORD_W-1:0] srcWord, accum, nextAcc, holdWord;
  logic [POS_W-1:0]  srcPos, accCnt;
  logic              srcHave, lineFinished, holdValid, holdLast;
  logic [IDX_W-1:0]  wrIdx, lastIdx, rdIdx;
  logic [WORD_W-1:0] lineBuf [DEPTH];

  logic curBit, lastRep, lastBit, lineEnd, genStep, wordFull, emitWord;
  logic srcTake, holdTake, replayTake, rdLast;

  // configuration clamping
  always_comb begin
    if (factorIn == '0)          facNorm = FAC_ONE;
    else if (factorIn > FAC_MAX) facNorm = FAC_MAX;
    else                         facNorm = factorIn;
    if (lineLenIn == '0)          lenNorm = LEN_ONE;
    else if (lineLenIn > LEN_MAX) lenNorm = LEN_MAX;
    else                          lenNorm = lineLenIn;
  end

  assign curBit     = srcWord[~srcPos];
  assign lastRep    = (repCnt == facCfg - FAC_ONE);
  assign lastBit    = (bitCnt == lenCfg - LEN_ONE);
  assign lineEnd    = lastRep && lastBit;
  assign genStep    = strobes.expandEn && srcHave && !holdValid;
  assign wordFull   = (accCnt == POS_END);
  assign emitWord   = genStep && (wordFull || lineEnd);
  assign srcReady   = strobes.expandEn && !srcHave && !lineFinished;
  assign srcTake    = srcReady && srcValid;
  assign holdTake   = strobes.expandEn && holdValid && outReady;
  assign replayTake = strobes.replayEn && outReady;
  assign rdLast     = (rdIdx == lastIdx);

  always_comb begin
    nextAcc          = accum;
    nextAcc[~accCnt] = curBit;
  end

  always_comb begin
    status.expandLineAccepted = holdTake && holdLast;
    status.replayLineAccepted = replayTake && rdLast;
    status.lastReplay         = (lineCnt == facCfg - FAC_TWO);
    status.singleCopy         = (facCfg == FAC_ONE);
  end

  assign outValid = (strobes.expandEn && holdValid) || strobes.replayEn;
  assign outData  = strobes.replayEn ? lineBuf[rdIdx] : holdWord;
  assign outLast  = strobes.replayEn ? rdLast : holdLast;

  // line store for vertical replay
  always_ff @(posedge clk) begin
    if (emitWord) lineBuf[wrIdx] <= nextAcc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      facCfg       <= FAC_ONE;
      lenCfg       <= LEN_ONE;
      srcWord      <= '0;
      srcPos       <= '0;
      srcHave      <= 1'b0;
      lineFinished <= 1'b0;
      repCnt       <= '0;
      bitCnt       <= '0;
      accum        <= '0;
      accCnt       <= '0;
      holdWord     <= '0;
      holdValid    <= 1'b0;
      holdLast     <= 1'b0;
      wrIdx        <= '0;
      lastIdx      <= '0;
      rdIdx        <= '0;
      lineCnt      <= '0;
    end else if (strobes.loadCfg) begin
      facCfg       <= facNorm;
      lenCfg       <= lenNorm;
      srcPos       <= '0;
      srcHave      <= 1'b0;
      lineFinished <= 1'b0;
      repCnt       <= '0;
      bitCnt       <= '0;
      accum        <= '0;
      accCnt       <= '0;
      holdValid    <= 1'b0;
      holdLast     <= 1'b0;
      wrIdx        <= '0;
      lastIdx      <= '0;
      rdIdx        <= '0;
      lineCnt      <= '0;
    end else begin
      if (srcTake) begin
        srcWord <= srcData;
        srcPos  <= '0;
        srcHave <= 1'b1;
      end

      if (genStep) begin
        if (lastRep) begin
          repCnt <= '0;
          bitCnt <= bitCnt + LEN_ONE;
          srcPos <= srcPos + POS_W'(1);
          if (srcPos == POS_END || lastBit) srcHave <= 1'b0;
          if (lastBit) lineFinished <= 1'b1;
        end else begin
          repCnt <= repCnt + FAC_ONE;
        end
        if (wordFull || lineEnd) begin
          holdWord  <= nextAcc;
          holdValid <= 1'b1;
          holdLast  <= lineEnd;
          wrIdx     <= wrIdx + IDX_W'(1);
          accum     <= '0;
          accCnt    <= '0;
          if (lineEnd) lastIdx <= wrIdx;
        end else begin
          accum  <= nextAcc;
          accCnt <= accCnt + POS_W'(1);
        end
      end

      if (holdTake) holdValid <= 1'b0;

      if (replayTake) begin
        if (rdLast) begin
          rdIdx   <= '0;
          lineCnt <= lineCnt + FAC_ONE;
        end else begin
          rdIdx <= rdIdx + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/bitmap_magnifier.sv
module bitmap_magnifier
  import magnifier_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int MAX_LEN    = 256,
  parameter int MAX_FACTOR = 10
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              startPulse,
  input  logic [$clog2(MAX_FACTOR+1)-1:0]   factorIn,
  input  logic [$clog2(MAX_LEN+1)-1:0]      lineLenIn,
  input  logic [WORD_W-1:0]                 srcData,
  input  logic                              srcValid,
  output logic                              srcReady,
  output logic [WORD_W-1:0]                 outData,
  output logic                              outValid,
  input  logic                              outReady,
  output logic                              outLast,
  output logic                              donePulse,
  output logic                              busy
);

  ctlStrobe_t strobes;
  dpStatus_t  status;

  magnifier_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .status     (status),
    .strobes    (strobes),
    .busy       (busy),
    .donePulse  (donePulse)
  );

  magnifier_datapath #(
    .WORD_W     (WORD_W),
    .MAX_LEN    (MAX_LEN),
    .MAX_FACTOR (MAX_FACTOR)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .factorIn   (factorIn),
    .lineLenIn  (lineLenIn),
    .srcData    (srcData),
    .srcValid   (srcValid),
    .srcReady   (srcReady),
    .outData    (outData),
    .outValid   (outValid),
    .outReady   (outReady),
    .outLast    (outLast),
    .status     (status)
  );

endmodule

// File: rtl/magnifier_checker.sv
module magnifier_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              srcReady,
  input logic [WORD_W-1:0] outData,
  input logic              outValid,
  input logic              outReady,
  input logic              outLast,
  input logic              donePulse,
  input logic              busy
);

  // R6: a stalled word stays offered and unchanged
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R7: completion is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R7: idle while completion is signalled
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

  // R9: handshakes only while a run is active
  assert_src_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> busy);

  assert_out_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  // R9: an idle start launches a run
  assert_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> busy);

  // R8: a start during a run does not end it
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !outValid) |=> busy);

endmodule

bind bitmap_magnifier magnifier_checker #(.WORD_W(WORD_W)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .srcReady   (srcReady),
  .outData    (outData),
  .outValid   (outValid),
  .outReady   (outReady),
  .outLast    (outLast),
  .donePulse  (donePulse),
  .busy       (busy)
);

// File: tb/test_bitmap_magnifier.sv
module test_bitmap_magnifier;

  localparam int WORD_W     = 32;
  localparam int MAX_LEN    = 256;
  localparam int MAX_FACTOR = 10;
  localparam int FAC_W      = $clog2(MAX_FACTOR + 1);
  localparam int LEN_W      = $clog2(MAX_LEN + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN, startPulse, srcValid, srcReady, outValid, outReady, outLast;
  logic              donePulse, busy;
  logic [FAC_W-1:0]  factorIn;
  logic [LEN_W-1:0]  lineLenIn;
  logic [WORD_W-1:0] srcData, outData;

  bitmap_magnifier #(
    .WORD_W(WORD_W), .MAX_LEN(MAX_LEN), .MAX_FACTOR(MAX_FACTOR)
  ) i_bitmap_magnifier (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .factorIn(factorIn),
    .lineLenIn(lineLenIn), .srcData(srcData), .srcValid(srcValid),
    .srcReady(srcReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outLast(outLast), .donePulse(donePulse), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [31:0] srcMem [10];
  int fEff, lEff;

  function automatic logic [31:0] stepRng(logic [31:0] v);
    logic [31:0] x = v;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic srcBit(int i);
    return srcMem[i / 32][31 - (i % 32)];
  endfunction

  function automatic logic [31:0] expWord(int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int k = w * 32 + b;
      if (k < lEff * fEff) r[31 - b] = srcBit(k / fEff);
    end
    return r;
  endfunction

  task automatic runOne(input int f, input int l, input bit bp, input bit midStart);
    int nW, srcWords, lineNo, wIdx, srcIdx, lastHs, t;
    bit doneSeen, prevHeld;
    logic [31:0] prevData;
    logic prevLast;
    string tag;
    fEff = (f == 0) ? 1 : ((f > MAX_FACTOR) ? MAX_FACTOR : f);
    lEff = (l == 0) ? 1 : ((l > MAX_LEN) ? MAX_LEN : l);
    tag  = (f == 0 || f > MAX_FACTOR) ? "R2" : ((l == 0 || l > MAX_LEN) ? "R3" : "R1");
    nW       = (lEff * fEff + 31) / 32;
    srcWords = (lEff + 31) / 32;
    for (int i = 0; i < 10; i++) begin
      rng = stepRng(rng);
      srcMem[i] = rng;
    end
    @(negedge clk);
    startPulse = 1'b1;
    factorIn   = FAC_W'(f);
    lineLenIn  = LEN_W'(l);
    @(negedge clk);
    startPulse = 1'b0;
    check(busy === 1'b1, "R9", "busy after start", 32'(busy), 32'd1);
    lineNo = 0; wIdx = 0; srcIdx = 0; lastHs = -10; t = 0;
    doneSeen = 0; prevHeld = 0; prevData = '0; prevLast = 0;
    while (t < 30000) begin
      if (donePulse) begin
        doneSeen = 1;
        check(t == lastHs + 1, "R7", "done cycle after last word", 32'(t), 32'(lastHs + 1));
        check(busy === 1'b0, "R7", "busy low at done", 32'(busy), 32'd0);
        break;
      end
      if (prevHeld)
        check(outValid && outData === prevData && outLast === prevLast, "R6",
              "stalled word changed", outData, prevData);
      startPulse = (midStart && t == 3);
      factorIn   = midStart ? FAC_W'((f % 10) + 2) : FAC_W'(f);
      lineLenIn  = midStart ? LEN_W'(l + 3) : LEN_W'(l);
      rng = stepRng(rng);
      outReady = bp ? (rng[1:0] != 2'b00) : 1'b1;
      srcValid = (srcIdx <= srcWords) && (bp ? rng[2] : 1'b1);
      srcData  = srcMem[srcIdx];
      if (srcValid && srcReady) srcIdx++;
      if (outValid && outReady) begin
        if (lineNo < fEff) begin
          check(outData === expWord(wIdx), tag, $sformatf("data line %0d word %0d", lineNo, wIdx),
                outData, expWord(wIdx));
          check(outLast === (wIdx == nW - 1), "R4", $sformatf("last flag word %0d", wIdx),
                32'(outLast), 32'(wIdx == nW - 1));
        end else begin
          check(1'b0, "R5", "word beyond final line", 32'(lineNo), 32'(fEff));
        end
        if (outLast) begin
          lineNo++;
          wIdx = 0;
        end else begin
          wIdx++;
        end
        lastHs = t;
      end
      prevHeld = outValid && !outReady;
      prevData = outData;
      prevLast = outLast;
      t++;
      @(negedge clk);
    end
    startPulse = 1'b0;
    srcValid   = 1'b0;
    check(doneSeen, "R7", "done pulse seen", 32'(doneSeen), 32'd1);
    check(lineNo == fEff, "R5", "line count", 32'(lineNo), 32'(fEff));
    check(srcIdx == srcWords, "R5", "source words taken", 32'(srcIdx), 32'(srcWords));
    @(negedge clk);
    check(!outValid && !srcReady && !busy, "R9", "idle after run",
          {29'd0, outValid, srcReady, busy}, 32'd0);
  endtask

  initial begin
    #(190000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lens [9];
    lens = '{0, 1, 5, 31, 32, 33, 100, 256, 300};
    rstN = 1'b0; startPulse = 1'b0; factorIn = '0; lineLenIn = '0;
    srcData = '0; srcValid = 1'b0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !outValid && !srcReady && !donePulse, "R9", "reset state",
          {28'd0, busy, outValid, srcReady, donePulse}, 32'd0);
    rstN = 1'b1;
    for (int f = 0; f <= 11; f++) begin
      for (int li = 0; li < 9; li++) begin
        runOne(f, lens[li], ((f + li) % 2) == 1, 1'b0);
      end
    end
    // R8: start during a run must not disturb it
    runOne(4, 100, 1'b0, 1'b1);
    runOne(7, 256, 1'b1, 1'b1);
    runOne(2, 33, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule